// File: doc/BRIEF.md
# Radar pulse and phase-code sequencer

This block sets the timing of a coherent pulse-radar echo for a direct digital synthesizer (DDS). It divides the system clock into a steady update tick, which is the DDS update clock. When an external trigger marks the start of a pulse repetition period, the block waits a programmed number of update ticks for the simulated target range. It then opens an echo window that spans one update tick per chip of the selected code. On every chip it issues a one-cycle update strobe and a 14-bit phase word for the synthesizer. The code is a fixed Barker sequence, a maximal-length LFSR sequence of 7 or 31 chips, or a plain rectangular pulse of a single chip.

The echo amplitude comes from an external table. The block captures the amplitude presented at `amp_in` when the window opens and drives it out only while the window is open. The block also counts the accepted pulses on `pulse_idx`, and that count can address the amplitude table. A separate clutter channel runs without stopping. It receives a refresh request once per pulse duration, whether or not an echo is in progress. A trigger that arrives before the current echo has finished is dropped and reported.

Top module: `radar_pulse_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `upd_strobe`, `echo_en`, `echo_amp`, `phase_word`, `clut_req`, `overlap_err` and `pulse_idx` are all zero.
- R2: Update ticks recur every `upd_div`+1 clock cycles. Within one echo window, consecutive `upd_strobe` pulses are exactly that many cycles apart.
- R3: A trigger is accepted only when no echo is waiting or active. Counting from the clock edge that samples an accepted trigger, the first strobe appears between D·P+1 and D·P+P cycles later, where D is `range_dly` and P is the tick period.
- R4: The chip code and the phase word follow these rules:
  - A chip bit of 1 gives phase word 0. A chip bit of 0 gives phase word 14'h2000, which is half a cycle.
  - `code_sel` encoding: 0 is a rectangular pulse (one chip, bit 1). 1 is the 13-chip Barker code 1111100110101, sent left to right. 2 is a 7-chip LFSR sequence. 3 is a 31-chip LFSR sequence.
  - LFSR form: a W-bit register starts at all ones. Each chip outputs bit 0, then the register shifts right and bit 0 XOR bit T enters at the top. (W,T) is (3,1) for select 2 and (5,2) for select 3.
  - `phase_word` holds its value between strobes.
- R5: `echo_en` rises together with the first strobe. It stays high for exactly L·P cycles, where L is the code length. Exactly L strobes occur, all while `echo_en` is high.
- R6: `amp_in` is captured when the window opens, and `echo_amp` holds that value for the whole window. Outside the window, `echo_amp` and `phase_word` are zero.
- R7: A trigger that arrives while an echo is waiting or active is ignored. It raises `overlap_err` for one cycle in the next cycle, and it changes neither the running echo nor `pulse_idx`.
- R8: `clut_req` is a one-cycle pulse. Once settled, it recurs every L·P cycles, where L is the length for the current `code_sel`. It runs independently of triggers.
- R9: `pulse_idx` increases by exactly one, wrapping, in the cycle after each accepted trigger. It changes at no other time.
- R10: `code_sel` and `range_dly` are captured at trigger acceptance. Changing them afterwards does not alter the delay or the code of the pulse in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_div | input | 8 | Tick period minus one, in clock cycles |
| code_sel | input | 2 | Code select (R4 encoding) |
| range_dly | input | 12 | Range delay in update ticks |
| prt_trig | input | 1 | Pulse repetition trigger, one cycle |
| amp_in | input | 12 | Echo amplitude from the external table |
| upd_strobe | output | 1 | DDS update strobe, one per chip |
| phase_word | output | 14 | Phase control word for the current chip |
| echo_en | output | 1 | Echo window / amplitude enable |
| echo_amp | output | 12 | Gated echo amplitude |
| clut_req | output | 1 | Clutter amplitude refresh request |
| overlap_err | output | 1 | A trigger was dropped because an echo was in progress |
| pulse_idx | output | 8 | Count of accepted pulses |

## Verification
The hardest cases to reach are triggers that collide with an echo already in progress. This can happen in the waiting phase, just after acceptance, or late in the window, including the cycle in which the window closes at divisor zero. The stimulus reaches these cases by timing extra triggers from what it observes at the ports: one trigger the cycle after acceptance, and one as soon as `echo_en` is seen high. Random divisors, delays and code selects are mixed with directed Barker, long-sequence and rectangular cases. The code select, range and amplitude inputs are changed during each pulse so that the capture behaviour is exercised.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [1:0] {
    CODE_RECT    = 2'd0,
    CODE_BARKER  = 2'd1,
    CODE_MLS7    = 2'd2,
    CODE_MLS31   = 2'd3
  } code_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ACTIVE = 2'd2
  } seq_st_e;

  localparam int CHIP_W = 5;
  localparam int BARKER_LEN = 13;
  localparam logic [BARKER_LEN-1:0] BARKER_BITS = 13'b1111100110101;

  function automatic logic [CHIP_W-1:0] code_len(code_e sel);
    case (sel)
      CODE_RECT:   code_len = CHIP_W'(1);
      CODE_BARKER: code_len = CHIP_W'(BARKER_LEN);
      CODE_MLS7:   code_len = CHIP_W'(7);
      default:     code_len = CHIP_W'(31);
    endcase
  endfunction

endpackage

// File: rtl/rs_lfsr.sv
module rs_lfsr #(
  parameter int W   = 3,
  parameter int TAP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  output logic bit_o
);

  logic [W-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load) begin
      sr_d = '1;
    end else if (step) begin
      sr_d = {sr_q[0] ^ sr_q[TAP], sr_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '1;
    end else if (load || step) begin
      sr_q <= sr_d;
    end
  end

  assign bit_o = sr_q[0];

endmodule

// File: rtl/rs_code_gen.sv
module rs_code_gen
  import rs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  code_e             sel,
  input  logic [CHIP_W-1:0] chip,
  output logic              bit_o
);

  localparam int N_LFSR = 2;

  logic [N_LFSR-1:0] mls_bit;
  logic [3:0]        b_idx;
  logic              barker_bit;

  for (genvar g = 0; g < N_LFSR; g++) begin : g_lfsr
    localparam int LW = (g == 0) ? 3 : 5;
    localparam int LT = (g == 0) ? 1 : 2;
    rs_lfsr #(
      .W  (LW),
      .TAP(LT)
    ) u_lfsr (
      .clk  (clk),
      .rst_n(rst_n),
      .load (load),
      .step (step),
      .bit_o(mls_bit[g])
    );
  end

  always_comb begin
    b_idx      = 4'(BARKER_LEN - 1) - chip[3:0];
    barker_bit = 1'b1;
    if (chip < CHIP_W'(BARKER_LEN)) begin
      barker_bit = BARKER_BITS[b_idx];
    end
  end

  always_comb begin
    case (sel)
      CODE_RECT:   bit_o = 1'b1;
      CODE_BARKER: bit_o = barker_bit;
      CODE_MLS7:   bit_o = mls_bit[0];
      default:     bit_o = mls_bit[1];
    endcase
  end

endmodule

// File: rtl/rs_tick_gen.sv
module rs_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q >= div);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rs_clutter.sv
module rs_clutter
  import rs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [CHIP_W-1:0] len,
  output logic              req
);

  logic [CHIP_W-1:0] cnt_q, cnt_d;
  logic              req_q, req_d;

  always_comb begin
    cnt_d = cnt_q;
    req_d = 1'b0;
    if (tick) begin
      if (cnt_q >= len - 1'b1) begin
        cnt_d = '0;
        req_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
      if (tick) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign req = req_q;

endmodule

// File: rtl/rs_pulse_fsm.sv
module rs_pulse_fsm
  import rs_pkg::*;
#(
  parameter int DLY_W = 12,
  parameter int AMP_W = 12,
  parameter int PH_W  = 14,
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              trig,
  input  code_e             sel_in,
  input  logic [DLY_W-1:0]  dly_in,
  input  logic [AMP_W-1:0]  amp_in,
  input  logic              code_bit,
  output logic              load,
  output logic              emit,
  output logic [CHIP_W-1:0] chip,
  output code_e             sel,
  output logic              strobe,
  output logic [PH_W-1:0]   phase,
  output logic              win,
  output logic [AMP_W-1:0]  amp,
  output logic              ovl,
  output logic [IDX_W-1:0]  idx
);

  localparam logic [PH_W-1:0] PH_HALF = PH_W'(1) << (PH_W - 1);

  seq_st_e           st_q, st_d;
  logic [DLY_W-1:0]  dcnt_q, dcnt_d;
  logic [CHIP_W-1:0] chip_q, chip_d;
  code_e             sel_q, sel_d;
  logic [AMP_W-1:0]  amp_q, amp_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic              stb_q, stb_d;
  logic              ovl_q, ovl_d;
  logic [IDX_W-1:0]  idx_q, idx_d;

  always_comb begin
    st_d   = st_q;
    dcnt_d = dcnt_q;
    chip_d = chip_q;
    sel_d  = sel_q;
    amp_d  = amp_q;
    ph_d   = ph_q;
    idx_d  = idx_q;
    stb_d  = 1'b0;
    ovl_d  = 1'b0;
    load   = 1'b0;
    emit   = 1'b0;

    if (trig) begin
      if (st_q == ST_IDLE) begin
        st_d   = ST_WAIT;
        dcnt_d = dly_in;
        sel_d  = sel_in;
        chip_d = '0;
        idx_d  = idx_q + 1'b1;
        load   = 1'b1;
      end else begin
        ovl_d = 1'b1;
      end
    end

    if (tick) begin
      case (st_q)
        ST_WAIT: begin
          if (dcnt_q == '0) begin
            st_d   = ST_ACTIVE;
            amp_d  = amp_in;
            chip_d = CHIP_W'(1);
            emit   = 1'b1;
          end else begin
            dcnt_d = dcnt_q - 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (chip_q == code_len(sel_q)) begin
            st_d = ST_IDLE;
            ph_d = '0;
          end else begin
            chip_d = chip_q + 1'b1;
            emit   = 1'b1;
          end
        end
        default: ;
      endcase
    end

    if (emit) begin
      stb_d = 1'b1;
      ph_d  = code_bit ? '0 : PH_HALF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dcnt_q <= '0;
      chip_q <= '0;
      sel_q  <= CODE_RECT;
      amp_q  <= '0;
      ph_q   <= '0;
      stb_q  <= 1'b0;
      ovl_q  <= 1'b0;
      idx_q  <= '0;
    end else begin
      st_q  <= st_d;
      stb_q <= stb_d;
      ovl_q <= ovl_d;
      ph_q  <= ph_d;
      if (load || tick) begin
        dcnt_q <= dcnt_d;
        chip_q <= chip_d;
      end
      if (load) begin
        sel_q <= sel_d;
        idx_q <= idx_d;
      end
      if (emit) begin
        amp_q <= amp_d;
      end
    end
  end

  assign chip   = chip_q;
  assign sel    = sel_q;
  assign strobe = stb_q;
  assign phase  = ph_q;
  assign win    = (st_q == ST_ACTIVE);
  assign amp    = win ? amp_q : '0;
  assign ovl    = ovl_q;
  assign idx    = idx_q;

endmodule

// File: rtl/radar_pulse_seq.sv
module radar_pulse_seq
  import rs_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DLY_W = 12,
  parameter int AMP_W = 12,
  parameter int PH_W  = 14,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] upd_div,
  input  logic [1:0]       code_sel,
  input  logic [DLY_W-1:0] range_dly,
  input  logic             prt_trig,
  input  logic [AMP_W-1:0] amp_in,
  output logic             upd_strobe,
  output logic [PH_W-1:0]  phase_word,
  output logic             echo_en,
  output logic [AMP_W-1:0] echo_amp,
  output logic             clut_req,
  output logic             overlap_err,
  output logic [IDX_W-1:0] pulse_idx
);

  logic              tick;
  logic              load, emit, code_bit;
  logic [CHIP_W-1:0] chip;
  code_e             sel_live, sel_held;

  assign sel_live = code_e'(code_sel);

  rs_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (upd_div),
    .tick (tick)
  );

  rs_clutter u_clut (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .len  (code_len(sel_live)),
    .req  (clut_req)
  );

  rs_code_gen u_code (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load),
    .step (emit),
    .sel  (sel_held),
    .chip (chip),
    .bit_o(code_bit)
  );

  rs_pulse_fsm #(
    .DLY_W(DLY_W),
    .AMP_W(AMP_W),
    .PH_W (PH_W),
    .IDX_W(IDX_W)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .trig    (prt_trig),
    .sel_in  (sel_live),
    .dly_in  (range_dly),
    .amp_in  (amp_in),
    .code_bit(code_bit),
    .load    (load),
    .emit    (emit),
    .chip    (chip),
    .sel     (sel_held),
    .strobe  (upd_strobe),
    .phase   (phase_word),
    .win     (echo_en),
    .amp     (echo_amp),
    .ovl     (overlap_err),
    .idx     (pulse_idx)
  );

endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int AMP_W = 12,
  parameter int PH_W  = 14,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             prt_trig,
  input logic             upd_strobe,
  input logic [PH_W-1:0]  phase_word,
  input logic             echo_en,
  input logic [AMP_W-1:0] echo_amp,
  input logic             overlap_err,
  input logic [IDX_W-1:0] pulse_idx
);

  localparam logic [PH_W-1:0] HALF = PH_W'(1) << (PH_W - 1);

  assert_overlap_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prt_trig && echo_en) |=> overlap_err);

  assert_overlap_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_err |-> $past(prt_trig));

  assert_strobe_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_strobe |-> echo_en);

  assert_gated_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !echo_en |-> (echo_amp == '0 && phase_word == '0));

  assert_amp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_en && $past(echo_en)) |-> $stable(echo_amp));

  assert_phase_values_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_word == '0) || (phase_word == HALF));

  assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_en && !upd_strobe) |-> $stable(phase_word));

  assert_idx_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pulse_idx) |-> (pulse_idx == IDX_W'($past(pulse_idx) + 1'b1)));

endmodule

bind radar_pulse_seq rs_checker #(
  .AMP_W(AMP_W),
  .PH_W (PH_W),
  .IDX_W(IDX_W)
) u_rs_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .prt_trig   (prt_trig),
  .upd_strobe (upd_strobe),
  .phase_word (phase_word),
  .echo_en    (echo_en),
  .echo_amp   (echo_amp),
  .overlap_err(overlap_err),
  .pulse_idx  (pulse_idx)
);

// File: tb/radar_pulse_seq_bench.sv
`timescale 1ns/1ps
module radar_pulse_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  upd_div;
  logic [1:0]  code_sel;
  logic [11:0] range_dly;
  logic        prt_trig;
  logic [11:0] amp_in;
  logic        upd_strobe;
  logic [13:0] phase_word;
  logic        echo_en;
  logic [11:0] echo_amp;
  logic        clut_req;
  logic        overlap_err;
  logic [7:0]  pulse_idx;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  radar_pulse_seq u_radar_pulse_seq (
    .clk(clk), .rst_n(rst_n), .upd_div(upd_div), .code_sel(code_sel),
    .range_dly(range_dly), .prt_trig(prt_trig), .amp_in(amp_in),
    .upd_strobe(upd_strobe), .phase_word(phase_word), .echo_en(echo_en),
    .echo_amp(echo_amp), .clut_req(clut_req), .overlap_err(overlap_err),
    .pulse_idx(pulse_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clen(input int sel);
    case (sel)
      0: return 1;
      1: return 13;
      2: return 7;
      default: return 31;
    endcase
  endfunction

  function automatic bit cbit(input int sel, input int i);
    logic [12:0] bk = 13'b1111100110101;
    logic [4:0]  s  = 5'h1f;
    int w   = (sel == 2) ? 3 : 5;
    int tap = (sel == 2) ? 1 : 2;
    bit fb;
    if (sel == 0) return 1'b1;
    if (sel == 1) return bk[12-i];
    if (w == 3) s = 5'h07;
    for (int j = 0; j < i; j++) begin
      fb = s[0] ^ s[tap];
      s  = (s >> 1) | (5'(fb) << (w - 1));
    end
    return s[0];
  endfunction

  task automatic run_pulse(input int sel, input int div, input int dly,
                           input logic [11:0] amp, input bit ovl_wait, input bit ovl_act);
    int p = div + 1;
    int len = clen(sel);
    int k = 0, first_k = -1, last_k = -1, nstb = 0, hi = 0, ovl_k = -1;
    bit done = 0, amp_bad = 0, ph_bad = 0, sp_bad = 0;
    logic [7:0] idx0;
    @(negedge clk);
    upd_div = 8'(div); code_sel = 2'(sel); range_dly = 12'(dly); amp_in = amp;
    idx0 = pulse_idx;
    prt_trig = 1'b1;
    @(negedge clk);
    prt_trig = 1'b0;
    chk(pulse_idx == idx0 + 8'd1, "R9", pulse_idx, idx0 + 8'd1);
    // R10: change the configuration after acceptance
    code_sel  = 2'(sel) ^ 2'b01;
    range_dly = 12'(dly + 5);
    if (ovl_wait) begin prt_trig = 1'b1; ovl_k = 1; end
    while (!done && k < 3000) begin
      @(negedge clk);
      k++;
      prt_trig = 1'b0;
      if (ovl_k == k) chk(overlap_err == 1'b1, "R7", overlap_err, 1);
      if (echo_en) begin
        hi++;
        if (echo_amp != amp) amp_bad = 1;
      end
      if (upd_strobe) begin
        if (nstb > 0 && (k - last_k) != p) sp_bad = 1;
        if (nstb >= len) ph_bad = 1;
        else if (phase_word != (cbit(sel, nstb) ? 14'h0 : 14'h2000)) ph_bad = 1;
        if (nstb == 0) first_k = k;
        last_k = k;
        nstb++;
        if (nstb == 1) amp_in = ~amp;
      end
      if (hi > 0 && !echo_en) done = 1;
      if (ovl_act && ovl_k < 0 && echo_en) begin prt_trig = 1'b1; ovl_k = k + 1; end
    end
    chk(first_k >= dly * p + 1 && first_k <= dly * p + p, "R3 delay", first_k, dly * p + p);
    chk(!sp_bad, "R2 spacing", sp_bad, 0);
    chk(!ph_bad, "R4/R10 phase code", ph_bad, 0);
    chk(nstb == len, "R5 chip count", nstb, len);
    chk(hi == len * p, "R5 window length", hi, len * p);
    chk(!amp_bad, "R6 amplitude held", amp_bad, 0);
    chk(echo_amp == 0 && phase_word == 0, "R6 gated off", echo_amp + phase_word, 0);
    chk(pulse_idx == idx0 + 8'd1, "R7/R9 index after overlap", pulse_idx, idx0 + 8'd1);
  endtask

  task automatic clut_check(input int sel, input int div);
    int k = 0, seen = 0, prev = -1, intv = -1, intv2 = -1;
    @(negedge clk);
    code_sel = 2'(sel); upd_div = 8'(div);
    while (seen < 4 && k < 2000) begin
      @(negedge clk);
      k++;
      if (clut_req) begin
        if (seen == 2) intv = k - prev;
        if (seen == 3) intv2 = k - prev;
        prev = k;
        seen++;
      end
    end
    chk(intv == clen(sel) * (div + 1) && intv2 == intv, "R8 clutter period", intv, clen(sel) * (div + 1));
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    rst_n = 1'b0; prt_trig = 1'b0; upd_div = 8'd1; code_sel = 2'd0;
    range_dly = 12'd0; amp_in = 12'd0;
    repeat (3) @(negedge clk);
    chk(!upd_strobe && !echo_en && echo_amp == 0 && phase_word == 0 && !clut_req
        && !overlap_err && pulse_idx == 0, "R1 reset", echo_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!upd_strobe && !echo_en && pulse_idx == 0 && !overlap_err, "R1 after release", pulse_idx, 0);
    // directed corners
    run_pulse(1, 2, 3, 12'h5a5, 0, 0);   // Barker
    run_pulse(3, 0, 0, 12'h0f1, 0, 0);   // 31-chip, tick every cycle
    run_pulse(0, 3, 0, 12'h7ff, 0, 1);   // rectangular, overlap late
    run_pulse(2, 1, 2, 12'h123, 1, 1);   // 7-chip, overlap while waiting and active
    run_pulse(0, 0, 1, 12'habc, 0, 1);   // overlap on closing cycle at divisor zero
    for (int t = 0; t < 24; t++) begin
      run_pulse(int'($urandom % 4), int'($urandom % 4), int'($urandom % 5),
                12'($urandom), bit'($urandom % 2), bit'($urandom % 2));
    end
    clut_check(1, 1);
    clut_check(0, 2);
    clut_check(2, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule